// File: doc/BRIEF.md
# Store Write Buffer with Coalescing and Load Forwarding

This block holds a few pending stores between a cache and a slower memory. A store, made of an address, a data word and a byte mask, is taken in the cycle it is offered as long as room exists. The buffer then hands entries to memory one at a time, oldest first, over a valid/ready handshake. The producer never waits on memory unless every slot is occupied.

A store whose address is already queued is folded into that entry under its byte mask, so repeated writes to one word cost a single memory transfer. The only exception is the oldest entry while it is being offered to memory. A load probe compares its address against every queued entry and returns the newest bytes for that address, together with a mask that shows which bytes the buffer can supply. An empty flag tells the upstream cache when all pending writes have reached memory.

A two-state drain controller sequences the memory side. In DR_IDLE the memory request is low. The transition DR_IDLE -> DR_SEND happens when at least one entry is queued. In DR_SEND the oldest entry is offered and locked. The transition DR_SEND -> DR_SEND happens on a handshake that leaves entries behind, and the next entry is offered at once. The transition DR_SEND -> DR_IDLE happens on a handshake that leaves the buffer empty.

Top module: `store_wbuf`

## Requirements
- R1: After reset `empty` is 1, `mem_valid` is 0, `st_ready` is 1 and `ld_hit` is 0.
- R2: A store offered with `st_ready` high is taken at that clock edge, and `empty` is 0 from the next cycle.
- R3: Entries reach memory in the order they were created. `mem_valid` rises the cycle after the first entry appears. While `mem_ready` is low, `mem_addr`, `mem_data` and `mem_mask` hold steady. Bytes outside `mem_mask` read as zero.
- R4: A store to an address held by an entry that is not being offered to memory merges into that entry. Its enabled bytes replace the older ones, the masks are ORed, and no slot is taken.
- R5: A store to the address of the entry being offered to memory (`mem_valid` high) takes a fresh slot, and both entries are later written to memory.
- R6: `ld_hit` is 1 in the same cycle when `ld_addr` matches a queued entry. `ld_data` holds the newest queued byte for each byte lane, with younger entries winning. `ld_mask` is the OR of the masks of the matching entries. Lanes that no matching entry covers read as zero.
- R7: With all DEPTH slots occupied, no handshake on the memory side and no matching unlocked entry, `st_ready` is 0.
- R8: With the buffer full, a store offered in the cycle a memory handshake completes sees `st_ready` at 1 and is taken.
- R9: With the buffer full, a store that can merge into an unlocked entry sees `st_ready` at 1.
- R10: `empty` is 1 exactly when no entry is queued, and then `mem_valid` and `ld_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_mask | input | DATA_W/8 | Store byte enables |
| ld_addr | input | ADDR_W | Load probe address |
| ld_hit | output | 1 | Probe address is queued |
| ld_data | output | DATA_W | Forwarded bytes |
| ld_mask | output | DATA_W/8 | Lanes supplied by the buffer |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_addr | output | ADDR_W | Address of offered entry |
| mem_data | output | DATA_W | Data of offered entry |
| mem_mask | output | DATA_W/8 | Byte enables of offered entry |
| empty | output | 1 | No entry queued |

## Verification
The hardest case to reach is a full buffer in which the locked oldest entry and a younger entry share one address, and a store arrives in the same cycle that memory takes the locked entry. The stimulus holds `mem_ready` low so that the controller locks the first entry. It then stores to that address again, fills the rest, and raises `mem_ready` only while the next store is already offered. A randomized phase follows, with five addresses competing for four slots and a back-pressured memory, so that merges, locked-entry splits and full stalls keep colliding with handshakes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_e;
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH = 4,
    parameter int ADDR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [ADDR_W-1:0] probe,
    input  logic              lock_on,
    input  logic [PTR_W-1:0]  lock_idx,
    output logic [DEPTH-1:0]  hit_free
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic is_locked;
        assign is_locked   = lock_on && (lock_idx == PTR_W'(g));
        assign hit_free[g] = slot_vld[g] && (slot_addr[g] == probe) && !is_locked;
    end

    // R4
    one_free_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_free));
endmodule

// File: rtl/wbuf_drain_fsm.sv
module wbuf_drain_fsm
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_now,
    input  logic pending_next,
    input  logic mem_ready,
    output logic sending,
    output logic pop
);
    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (pending_now) state_d = DR_SEND;
            DR_SEND: if (mem_ready && !pending_next) state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        sending = (state_q == DR_SEND);
        pop     = sending && mem_ready;
    end

    // R3
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !mem_ready) |=> sending);
endmodule

// File: rtl/store_wbuf.sv
module store_wbuf
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_mask,
    input  logic [ADDR_W-1:0]     ld_addr,
    output logic                  ld_hit,
    output logic [DATA_W-1:0]     ld_data,
    output logic [DATA_W/8-1:0]   ld_mask,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic [DATA_W/8-1:0]   mem_mask,
    output logic                  empty
);
    localparam int BYTES = DATA_W / 8;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [BYTES-1:0]  q_mask [DEPTH];
    logic [DEPTH-1:0]  q_vld;

    logic [PTR_W-1:0]  head, tail, merge_idx;
    logic [CNT_W-1:0]  count, count_next;
    logic              sending, pop, full;
    logic              merge_hit, push_new, do_merge, ld_head_hit;
    logic [DEPTH-1:0]  st_hit, ld_free;
    logic [DATA_W-1:0] st_data_m;

    wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_st_match (
        .clk(clk), .rst_n(rst_n), .slot_vld(q_vld), .slot_addr(q_addr),
        .probe(st_addr), .lock_on(sending), .lock_idx(head), .hit_free(st_hit)
    );

    wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ld_match (
        .clk(clk), .rst_n(rst_n), .slot_vld(q_vld), .slot_addr(q_addr),
        .probe(ld_addr), .lock_on(sending), .lock_idx(head), .hit_free(ld_free)
    );

    wbuf_drain_fsm u_drain (
        .clk(clk), .rst_n(rst_n),
        .pending_now(count != '0), .pending_next(count_next != '0),
        .mem_ready(mem_ready), .sending(sending), .pop(pop)
    );

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (st_hit[i]) merge_idx = PTR_W'(i);
    end

    always_comb begin
        merge_hit  = |st_hit;
        full       = (count == CNT_W'(DEPTH));
        st_ready   = !full || pop || merge_hit;
        push_new   = st_valid && st_ready && !merge_hit;
        do_merge   = st_valid && merge_hit;
        count_next = count + CNT_W'(push_new) - CNT_W'(pop);
    end

    always_comb begin
        for (int b = 0; b < BYTES; b++)
            st_data_m[b*8 +: 8] = st_mask[b] ? st_data[b*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            q_vld <= '0;
        end else begin
            count <= count_next;
            if (pop) begin
                q_vld[head] <= 1'b0;
                head        <= head + 1'b1;
            end
            if (push_new) begin
                q_vld[tail] <= 1'b1;
                tail        <= tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_new) begin
            q_addr[tail] <= st_addr;
            q_data[tail] <= st_data_m;
            q_mask[tail] <= st_mask;
        end
        if (do_merge) begin
            for (int b = 0; b < BYTES; b++)
                if (st_mask[b]) q_data[merge_idx][b*8 +: 8] <= st_data[b*8 +: 8];
            q_mask[merge_idx] <= q_mask[merge_idx] | st_mask;
        end
    end

    always_comb begin
        mem_valid = sending;
        mem_addr  = q_addr[head];
        mem_data  = q_data[head];
        mem_mask  = q_mask[head];
        empty     = (count == '0);
    end

    always_comb begin
        ld_head_hit = sending && q_vld[head] && (q_addr[head] == ld_addr);
        ld_data     = '0;
        ld_mask     = '0;
        if (ld_head_hit) begin
            ld_data = q_data[head];
            ld_mask = q_mask[head];
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (ld_free[i]) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (q_mask[i][b]) begin
                        ld_data[b*8 +: 8] = q_data[i][b*8 +: 8];
                        ld_mask[b]        = 1'b1;
                    end
                end
            end
        end
        ld_hit = ld_head_hit || (|ld_free);
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R2
    accept_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> !empty);

    // R4
    merge_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && merge_hit) |=> (count == $past(count) - CNT_W'($past(pop))));

    // R10
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (!mem_valid && !ld_hit));
endmodule

// File: tb/store_wbuf_test.sv
module store_wbuf_test;
    typedef struct {
        logic [15:0] a;
        logic [31:0] d;
        logic [3:0]  m;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [15:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_mask = '0;
    logic [15:0] ld_addr;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic [3:0]  ld_mask;
    logic        mem_valid;
    logic        mem_ready;
    logic [15:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_mask;
    logic        empty;

    logic        rand_on = 1'b0;
    logic        rdy_force = 1'b0;
    logic        rnd_bit = 1'b0;
    logic [15:0] ld_force = 16'h0000;
    logic [15:0] rnd_ld = 16'h0000;

    int n_chk = 0;
    int n_bad = 0;
    int drains = 0;
    ent_t mq[$];

    assign mem_ready = rand_on ? rnd_bit : rdy_force;
    assign ld_addr   = rand_on ? rnd_ld : ld_force;

    always #5 clk = ~clk;

    store_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_mask(st_mask),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_mask(ld_mask),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_mask(mem_mask), .empty(empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_addr();
        return 16'h0010 + 16'(($urandom % 5) * 4);
    endfunction

    always @(posedge clk) begin
        #1;
        rnd_bit = ($urandom % 3) != 0;
        rnd_ld  = pick_addr();
    end

    // scoreboard monitor: forwarding, drain order, model update
    always @(negedge clk) begin
        logic        eh;
        logic [31:0] ed;
        logic [3:0]  em;
        int          idx;
        ent_t        e;
        if (rst_n) begin
            eh = 1'b0; ed = '0; em = '0;
            foreach (mq[i]) begin
                if (mq[i].a == ld_addr) begin
                    eh = 1'b1;
                    for (int b = 0; b < 4; b++)
                        if (mq[i].m[b]) begin
                            ed[b*8 +: 8] = mq[i].d[b*8 +: 8];
                            em[b] = 1'b1;
                        end
                end
            end
            chk("R6 ld_hit", ld_hit, eh);
            if (eh) begin
                chk("R6 ld_data", ld_data, ed);
                chk("R6 ld_mask", ld_mask, em);
            end
            chk("R10 empty flag", empty, mq.size() == 0);
            if (mem_valid && mem_ready) begin
                drains++;
                if (mq.size() == 0) chk("R3 drain with nothing queued", 1, 0);
                else begin
                    chk("R3 mem_addr order", mem_addr, mq[0].a);
                    chk("R3 mem_data", mem_data, mq[0].d);
                    chk("R3 mem_mask", mem_mask, mq[0].m);
                end
            end
            if (st_valid && st_ready) begin
                idx = -1;
                for (int i = (mem_valid ? 1 : 0); i < mq.size(); i++)
                    if (mq[i].a == st_addr) idx = i;
                if (idx >= 0) begin
                    e = mq[idx];
                    for (int b = 0; b < 4; b++)
                        if (st_mask[b]) e.d[b*8 +: 8] = st_data[b*8 +: 8];
                    e.m = e.m | st_mask;
                    mq[idx] = e;
                end else begin
                    e.a = st_addr; e.m = st_mask; e.d = '0;
                    for (int b = 0; b < 4; b++)
                        if (st_mask[b]) e.d[b*8 +: 8] = st_data[b*8 +: 8];
                    mq.push_back(e);
                end
            end
            if (mem_valid && mem_ready && mq.size() > 0) void'(mq.pop_front());
        end
    end

    // called at posedge+1; returns at posedge+1 after the store was taken
    task automatic store(input logic [15:0] a, input logic [31:0] d, input logic [3:0] m);
        st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
        @(negedge clk);
        while (!st_ready) @(negedge clk);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic wait_empty(input string tag);
        int k;
        k = 0;
        while (!empty && k < 200) begin
            @(posedge clk); #1; k++;
        end
        chk(tag, empty, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty", empty, 1'b1);
        chk("R1 mem_valid", mem_valid, 1'b0);
        chk("R1 st_ready", st_ready, 1'b1);
        chk("R1 ld_hit", ld_hit, 1'b0);
        @(posedge clk); #1;

        // R2 and R4: first store then merge before the entry is locked
        ld_force = 16'h0010;
        st_valid = 1'b1; st_addr = 16'h0010; st_data = 32'h11111111; st_mask = 4'hF;
        @(negedge clk);
        chk("R2 st_ready on first store", st_ready, 1'b1);
        @(posedge clk); #1;
        store(16'h0010, 32'h0000AAAA, 4'h3);
        @(negedge clk);
        chk("R2 empty after store", empty, 1'b0);
        chk("R3 mem_valid raised", mem_valid, 1'b1);
        chk("R4 merged data", mem_data, 32'h1111AAAA);
        chk("R4 merged mask", mem_mask, 4'hF);
        @(posedge clk); #1;

        // R5: same address while locked takes a new slot
        store(16'h0010, 32'h00BB0000, 4'h4);
        @(negedge clk);
        chk("R5 locked entry unchanged", mem_data, 32'h1111AAAA);
        chk("R6 youngest lane wins", ld_data, 32'h11BBAAAA);
        @(posedge clk); #1;

        store(16'h0020, 32'h22222222, 4'hF);
        store(16'h0030, 32'h000000CC, 4'h1);

        // R7: full, new address, no handshake
        st_valid = 1'b1; st_addr = 16'h0040; st_data = 32'h44444444; st_mask = 4'hF;
        @(negedge clk);
        chk("R7 stall when full", st_ready, 1'b0);
        @(posedge clk); #1;
        // R9: merge into an unlocked entry while full
        st_addr = 16'h0030; st_data = 32'h0000DD00; st_mask = 4'h2;
        @(negedge clk);
        chk("R9 merge accepted when full", st_ready, 1'b1);
        @(posedge clk); #1;
        st_valid = 1'b0;
        ld_force = 16'h0030;
        @(negedge clk);
        chk("R6 partial ld_mask", ld_mask, 4'h3);
        chk("R6 partial ld_data", ld_data, 32'h0000DDCC);
        @(posedge clk); #1;

        // R8: full, store arrives in the handshake cycle
        d0 = drains;
        st_valid = 1'b1; st_addr = 16'h0040; st_data = 32'h44444444; st_mask = 4'hF;
        rdy_force = 1'b1;
        @(negedge clk);
        chk("R8 accept during drain", st_ready, 1'b1);
        @(posedge clk); #1;
        st_valid = 1'b0;
        ld_force = 16'h0010;
        wait_empty("R10 drained to empty");
        @(negedge clk);
        chk("R3 five transfers", drains - d0, 5);
        chk("R10 no request when empty", mem_valid, 1'b0);
        chk("R10 no hit when empty", ld_hit, 1'b0);
        @(posedge clk); #1;

        // randomized phase with back-pressure
        rand_on = 1'b1;
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) begin
                @(posedge clk); #1;
            end else begin
                store(pick_addr(), $urandom, 4'(($urandom % 15) + 1));
            end
        end
        rand_on = 1'b0;
        rdy_force = 1'b1;
        wait_empty("R3 random phase drained");
        chk("R3 model empty", mq.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule